// File: doc/BRIEF.md
# Vector Operand Fetch and Swizzle Stage

This stage prepares the operands of a four-component vector instruction. Each source field of the instruction names a register bank and an index. The stage can add an address register to the index of exactly one source. It drives one read port per source towards the register banks, which sit outside the block. It then reorders the returned components through a per-source selector, optionally flips their sign, and registers the result. Every component is an opaque 24-bit floating-point word. No arithmetic happens here.

The same stage decodes the destination field into a bank select, a register index and an effective component write mask. The consumer applies that mask when it writes back, and disabled components keep their old value.

Results leave through a valid/ready interface with one register stage. A new instruction is accepted on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output register holds its contents and accepts nothing new.

Top module: `opf_top`

## Requirements
- R1: Each source field is 7 bits: bank code in bits [6:5] and index in bits [4:0]. Source slot s occupies `inst_src[7s+6:7s]`. The bank codes are 0 = input registers, 1 = temporaries, 2 = float uniforms and 3 = no bank. Bank code 3 yields a vector of all-zero words whatever comes back on the read port.
- R2: The address select `inst_asel` chooses the index offset. The values are 0 = none, 1 = `areg0`, 2 = `areg1` and 3 = none. The offset is added to the index modulo 32.
- R3: The offset applies to source slot 0 for normal forms (`inst_inv`=0) and to slot 1 for inverted-source forms (`inst_inv`=1), never to both. Multiply-add forms (`inst_mad`=1) apply no offset to any slot.
- R4: Vector component c sits at bits [24c+23:24c]. Output component i of slot s is the fetched component named by selector bits `inst_swz[8s+2i+1:8s+2i]`.
- R5: When `inst_neg[s]` is set, bit 23 of all four selected components of slot s is inverted. A zero word therefore becomes 0x800000.
- R6: The third source (slot 2) is delivered only for multiply-add forms. Otherwise its output vector is zero.
- R7: Destinations 0x00–0x0F select the output bank (`out_dest_bank`=0) and destinations 0x10–0x1F select temporaries (`out_dest_bank`=1). In both cases the index is the destination's low 4 bits. Destinations 0x20 and above produce a write mask of 0000.
- R8: For a destination in range, `out_mask` equals the instruction's 4-bit enable mask, where bit i enables component i.
- R9: An accepted instruction appears on the outputs one clock later with `out_valid` high. While `out_valid` is high and `out_ready` is low, the outputs stay stable and `in_ready` is low.
- R10: During and directly after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Stage can accept an instruction |
| inst_inv | input | 1 | Inverted-source form |
| inst_mad | input | 1 | Multiply-add form (three sources) |
| inst_asel | input | 2 | Address register select |
| inst_src | input | 21 | Three source fields, slot 0 in the low bits |
| inst_swz | input | 24 | Three 8-bit component selector sets |
| inst_neg | input | 3 | Per-slot negate |
| inst_dest | input | 7 | Destination field |
| inst_mask | input | 4 | Destination component enables |
| areg0 | input | 8 | First address register |
| areg1 | input | 8 | Second address register |
| rf_bank | output | 6 | Bank code per read port |
| rf_idx | output | 15 | Register index per read port |
| rf_data | input | 288 | Returned vector per read port, same cycle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_op | output | 288 | Three prepared source vectors |
| out_mask | output | 4 | Effective component write mask |
| out_dest_bank | output | 1 | 0 = output bank, 1 = temporaries |
| out_dest_idx | output | 4 | Destination register index |

## Verification
The bench first checks the offset steering. It uses an inverted form with a negative offset that wraps the index, and a large positive offset whose low bits wrap. A design that offset the wrong slot, or both slots, would return a word whose encoded index is off. It then checks that select value 3 and multiply-add forms leave every index raw. It negates the no-bank vector and expects 0x800000 rather than zero, which catches a design that subtracts instead of flipping the sign bit. It drives destinations 0x20 and 0x7F and expects a zero mask, catching a design that wraps them into the output bank. Finally it holds back-pressure on the output and presents a second instruction: a stage that overwrote or duplicated results would show the wrong vector or a premature `in_ready`.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int COMP_W = 24;
  localparam int NCOMP  = 4;
  localparam int VEC_W  = COMP_W * NCOMP;
  localparam int SEL_W  = 2;
  localparam int SWZ_W  = SEL_W * NCOMP;
  localparam int BANK_W = 2;
  localparam int NSRC   = 3;

  typedef enum logic [BANK_W-1:0] {
    BANK_IN   = 2'd0,
    BANK_TMP  = 2'd1,
    BANK_UNI  = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  // sign of a 24-bit float lives in its top bit
  function automatic logic [COMP_W-1:0] flip_sign(input logic [COMP_W-1:0] w);
    return {~w[COMP_W-1], w[COMP_W-2:0]};
  endfunction
endpackage

// File: rtl/opf_offset_sel.sv
module opf_offset_sel #(
  parameter int AREG_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic [1:0]        asel,
  input  logic [AREG_W-1:0] a0,
  input  logic [AREG_W-1:0] a1,
  input  logic              inv,
  input  logic              mad,
  output logic [IDX_W-1:0]  off,
  output logic [2:0]        slot_hit
);
  always_comb begin
    off = '0;
    unique case (asel)
      2'd1:    off = IDX_W'(a0);
      2'd2:    off = IDX_W'(a1);
      default: off = '0;
    endcase
  end

  // one slot at most takes the offset; three-source forms take none
  always_comb begin
    slot_hit = 3'b000;
    if (!mad && (asel == 2'd1 || asel == 2'd2)) begin
      if (inv) slot_hit[1] = 1'b1;
      else     slot_hit[0] = 1'b1;
    end
  end
endmodule

// File: rtl/opf_src_path.sv
module opf_src_path
  import opf_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [BANK_W+IDX_W-1:0] src_fld,
  input  logic [SWZ_W-1:0]        swz,
  input  logic                    neg,
  input  logic                    use_off,
  input  logic [IDX_W-1:0]        off,
  input  logic                    enable,
  output logic [BANK_W-1:0]       rd_bank,
  output logic [IDX_W-1:0]        rd_idx,
  input  logic [VEC_W-1:0]        rd_data,
  output logic [VEC_W-1:0]        vec
);
  bank_e            bank;
  logic [VEC_W-1:0] fetched;

  assign bank    = bank_e'(src_fld[IDX_W +: BANK_W]);
  assign rd_bank = bank;
  assign rd_idx  = src_fld[IDX_W-1:0] + (use_off ? off : '0);
  assign fetched = (bank == BANK_NONE) ? '0 : rd_data;

  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    logic [SEL_W-1:0]  sel;
    logic [COMP_W-1:0] picked;
    assign sel    = swz[i*SEL_W +: SEL_W];
    assign picked = fetched[sel*COMP_W +: COMP_W];
    assign vec[i*COMP_W +: COMP_W] =
      !enable ? '0 : (neg ? flip_sign(picked) : picked);
  end
endmodule

// File: rtl/opf_dest_decode.sv
module opf_dest_decode #(
  parameter int DEST_W = 7,
  parameter int DIDX_W = 4
) (
  input  logic [DEST_W-1:0] dest,
  input  logic [3:0]        mask_in,
  output logic              dbank,
  output logic [DIDX_W-1:0] didx,
  output logic [3:0]        mask_out
);
  localparam int REGION = 1 << DIDX_W;

  assign didx = dest[DIDX_W-1:0];

  always_comb begin
    dbank    = 1'b0;
    mask_out = 4'b0000;
    if (int'(dest) < REGION) begin
      dbank    = 1'b0;
      mask_out = mask_in;
    end else if (int'(dest) < 2 * REGION) begin
      dbank    = 1'b1;
      mask_out = mask_in;
    end
  end
endmodule

// File: rtl/opf_top.sv
module opf_top
  import opf_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int AREG_W = 8,
  parameter int DEST_W = 7,
  parameter int DIDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      inst_inv,
  input  logic                      inst_mad,
  input  logic [1:0]                inst_asel,
  input  logic [NSRC*(BANK_W+IDX_W)-1:0] inst_src,
  input  logic [NSRC*SWZ_W-1:0]     inst_swz,
  input  logic [NSRC-1:0]           inst_neg,
  input  logic [DEST_W-1:0]         inst_dest,
  input  logic [3:0]                inst_mask,
  input  logic [AREG_W-1:0]         areg0,
  input  logic [AREG_W-1:0]         areg1,
  output logic [NSRC*BANK_W-1:0]    rf_bank,
  output logic [NSRC*IDX_W-1:0]     rf_idx,
  input  logic [NSRC*VEC_W-1:0]     rf_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NSRC*VEC_W-1:0]     out_op,
  output logic [3:0]                out_mask,
  output logic                      out_dest_bank,
  output logic [DIDX_W-1:0]         out_dest_idx
);
  localparam int SRC_W  = BANK_W + IDX_W;
  localparam int REGION = 1 << DIDX_W;

  logic [IDX_W-1:0]      off;
  logic [2:0]            slot_hit;
  logic [NSRC*VEC_W-1:0] op_next;
  logic                  dbank_next;
  logic [DIDX_W-1:0]     didx_next;
  logic [3:0]            mask_next;
  logic                  accept;

  opf_offset_sel #(.AREG_W(AREG_W), .IDX_W(IDX_W)) u_off (
    .asel(inst_asel), .a0(areg0), .a1(areg1), .inv(inst_inv), .mad(inst_mad),
    .off(off), .slot_hit(slot_hit)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    opf_src_path #(.IDX_W(IDX_W)) u_path (
      .src_fld (inst_src[s*SRC_W +: SRC_W]),
      .swz     (inst_swz[s*SWZ_W +: SWZ_W]),
      .neg     (inst_neg[s]),
      .use_off (slot_hit[s]),
      .off     (off),
      .enable  ((s < 2) ? 1'b1 : inst_mad),
      .rd_bank (rf_bank[s*BANK_W +: BANK_W]),
      .rd_idx  (rf_idx[s*IDX_W +: IDX_W]),
      .rd_data (rf_data[s*VEC_W +: VEC_W]),
      .vec     (op_next[s*VEC_W +: VEC_W])
    );
  end

  opf_dest_decode #(.DEST_W(DEST_W), .DIDX_W(DIDX_W)) u_dest (
    .dest(inst_dest), .mask_in(inst_mask),
    .dbank(dbank_next), .didx(didx_next), .mask_out(mask_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_op        <= '0;
      out_mask      <= '0;
      out_dest_bank <= 1'b0;
      out_dest_idx  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_op        <= op_next;
        out_mask      <= mask_next;
        out_dest_bank <= dbank_next;
        out_dest_idx  <= didx_next;
      end
    end
  end

  // offset steering: the slot not chosen must see its raw index
  assert_raw_slot1_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !inst_inv) |-> rf_idx[IDX_W +: IDX_W] == inst_src[SRC_W +: IDX_W]);
  assert_raw_slot0_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inst_inv) |-> rf_idx[0 +: IDX_W] == inst_src[0 +: IDX_W]);
  assert_raw_all_mad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inst_mad) |-> (rf_idx[0 +: IDX_W] == inst_src[0 +: IDX_W]) &&
                               (rf_idx[IDX_W +: IDX_W] == inst_src[SRC_W +: IDX_W]));
  assert_no_third_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !inst_mad) |=> out_op[2*VEC_W +: VEC_W] == '0);
  assert_drop_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && int'(inst_dest) >= 2 * REGION) |=> out_mask == 4'b0000);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_op) && $stable(out_mask)
                                  && $stable(out_dest_idx));
  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_opf_top.sv
`timescale 1ns/1ps
module tb_opf_top;
  typedef struct packed {
    logic        inv;
    logic        mad;
    logic [1:0]  asel;
    logic [7:0]  a0;
    logic [7:0]  a1;
    logic [20:0] src;
    logic [23:0] swz;
    logic [2:0]  neg;
    logic [6:0]  dest;
    logic [3:0]  mask;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,2'd0,8'd0,8'd0,{7'h00,2'd1,5'd7,2'd0,5'd3},{8'hE4,8'hE4,8'hE4},3'b000,7'h05,4'hF},
    '{1'b0,1'b0,2'd1,8'd4,8'd0,{7'h00,2'd0,5'd2,2'd2,5'd10},{8'hE4,8'h00,8'h1B},3'b001,7'h12,4'b0101},
    '{1'b1,1'b0,2'd2,8'd0,8'hFD,{7'h00,2'd1,5'd1,2'd1,5'd1},{8'hE4,8'h4E,8'hE4},3'b010,7'h1F,4'b1000},
    '{1'b0,1'b1,2'd1,8'd5,8'd0,{2'd2,5'd31,2'd1,5'd4,2'd0,5'd8},{8'h55,8'hE4,8'hE4},3'b100,7'h00,4'b0011},
    '{1'b0,1'b0,2'd1,8'd1,8'd0,{7'h00,2'd0,5'd31,2'd3,5'd0},{8'hE4,8'hE4,8'hE4},3'b001,7'h20,4'hF},
    '{1'b0,1'b0,2'd3,8'd9,8'd9,{7'h00,2'd2,5'd0,2'd0,5'd6},{8'hE4,8'hB1,8'h9C},3'b000,7'h7F,4'hF},
    '{1'b1,1'b0,2'd1,8'h7F,8'd0,{7'h00,2'd2,5'd1,2'd0,5'd9},{8'hE4,8'hE4,8'hE4},3'b000,7'h0A,4'b0110},
    '{1'b1,1'b1,2'd2,8'd0,8'd3,{2'd0,5'd5,2'd1,5'd6,2'd2,5'd7},{8'h1B,8'h39,8'hE4},3'b111,7'h1C,4'hF}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, inst_inv, inst_mad;
  logic [1:0]   inst_asel;
  logic [20:0]  inst_src;
  logic [23:0]  inst_swz;
  logic [2:0]   inst_neg;
  logic [6:0]   inst_dest;
  logic [3:0]   inst_mask;
  logic [7:0]   areg0, areg1;
  logic [5:0]   rf_bank;
  logic [14:0]  rf_idx;
  logic [287:0] rf_data;
  logic         out_valid, out_ready;
  logic [287:0] out_op;
  logic [3:0]   out_mask;
  logic         out_dest_bank;
  logic [3:0]   out_dest_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opf_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .inst_inv(inst_inv), .inst_mad(inst_mad), .inst_asel(inst_asel),
    .inst_src(inst_src), .inst_swz(inst_swz), .inst_neg(inst_neg),
    .inst_dest(inst_dest), .inst_mask(inst_mask), .areg0(areg0), .areg1(areg1),
    .rf_bank(rf_bank), .rf_idx(rf_idx), .rf_data(rf_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_mask(out_mask), .out_dest_bank(out_dest_bank), .out_dest_idx(out_dest_idx)
  );

  // register-bank model: each word encodes bank, index and component
  function automatic logic [23:0] word(input logic [1:0] b, input logic [4:0] idx,
                                       input logic [1:0] c);
    return {4'hA, b, 2'b00, 3'b000, idx, 6'b000000, c};
  endfunction

  function automatic logic [95:0] bank_read(input logic [1:0] b, input logic [4:0] idx);
    logic [95:0] r;
    for (int c = 0; c < 4; c++)
      r[c*24 +: 24] = (b == 2'd3) ? 24'hFFFFFF : word(b, idx, 2'(c));
    return r;
  endfunction

  always_comb
    for (int s = 0; s < 3; s++)
      rf_data[s*96 +: 96] = bank_read(rf_bank[s*2 +: 2], rf_idx[s*5 +: 5]);

  // expected operand from the requirements
  function automatic logic [95:0] exp_vec(input vec_t v, input int s);
    logic [6:0]  fld;
    logic [4:0]  idx;
    logic [23:0] w;
    logic [95:0] r;
    fld = v.src[s*7 +: 7];
    idx = fld[4:0];
    if (s == 2 && !v.mad) return '0;                                  // R6
    if (!v.mad && (v.asel == 2'd1 || v.asel == 2'd2) && s == (v.inv ? 1 : 0))
      idx = idx + ((v.asel == 2'd1) ? v.a0[4:0] : v.a1[4:0]);         // R2 R3
    for (int i = 0; i < 4; i++) begin
      w = (fld[6:5] == 2'd3) ? 24'h0 : word(fld[6:5], idx, v.swz[s*8 + 2*i +: 2]); // R1 R4
      if (v.neg[s]) w[23] = ~w[23];                                   // R5
      r[i*24 +: 24] = w;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    inst_inv = v.inv; inst_mad = v.mad; inst_asel = v.asel;
    areg0 = v.a0; areg1 = v.a1; inst_src = v.src; inst_swz = v.swz;
    inst_neg = v.neg; inst_dest = v.dest; inst_mask = v.mask;
  endtask

  task automatic check_out(input vec_t v, input int n);
    logic [3:0] em;
    chk(out_valid == 1'b1, $sformatf("R9 valid vec%0d", n), 96'(out_valid), 96'd1);
    chk(out_op[0 +: 96] == exp_vec(v, 0), $sformatf("R1 R2 R3 R4 R5 slot0 vec%0d", n),
        out_op[0 +: 96], exp_vec(v, 0));
    chk(out_op[96 +: 96] == exp_vec(v, 1), $sformatf("R1 R2 R3 R4 R5 slot1 vec%0d", n),
        out_op[96 +: 96], exp_vec(v, 1));
    chk(out_op[192 +: 96] == exp_vec(v, 2), $sformatf("R6 slot2 vec%0d", n),
        out_op[192 +: 96], exp_vec(v, 2));
    em = (v.dest < 7'h20) ? v.mask : 4'b0000;
    chk(out_mask == em, $sformatf("R7 R8 mask vec%0d", n), 96'(out_mask), 96'(em));
    if (v.dest < 7'h20)
      chk({out_dest_bank, out_dest_idx} == {v.dest[4], v.dest[3:0]},
          $sformatf("R7 dest vec%0d", n), 96'({out_dest_bank, out_dest_idx}),
          96'({v.dest[4], v.dest[3:0]}));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    drive(TBL[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 in reset",
        96'({out_valid, in_ready}), 96'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 after reset",
        96'({out_valid, in_ready}), 96'b01);

    for (int n = 0; n < NV; n++) begin
      drive(TBL[n]);
      in_valid = 1'b1;
      chk(in_ready == 1'b1, "R9 ready when empty", 96'(in_ready), 96'd1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_out(TBL[n], n);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", 96'(out_valid), 96'd0);

    // R5 corner: negated no-bank vector must read 0x800000 per component
    chk(exp_vec(TBL[4], 0) == {4{24'h800000}}, "R5 negative zero model",
        exp_vec(TBL[4], 0), {4{24'h800000}});

    // R9 back-pressure
    out_ready = 1'b0;
    drive(TBL[1]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_out(TBL[1], 100);
    drive(TBL[3]);
    chk(in_ready == 1'b0, "R9 stall ready low", 96'(in_ready), 96'd0);
    @(posedge clk);
    @(negedge clk);
    chk(out_op[0 +: 96] == exp_vec(TBL[1], 0) && out_valid, "R9 held under stall",
        out_op[0 +: 96], exp_vec(TBL[1], 0));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(TBL[3], 101);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained after stall", 96'(out_valid), 96'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule